// File: doc/BRIEF.md
# Dual-Channel Input Controller Host Interface

This block is the host-facing side of a controller that serves two input devices: a main channel, usually a keyboard, and an auxiliary channel, usually a pointing device. The host sees a byte-wide bus with one address bit. One address holds the data register. The other reads back a status byte and takes controller commands when written. Bytes the host writes are kept in a one-entry input buffer. From there they either load an internal configuration byte, are decoded as a command, or go to one of the two device transmit streams.

Bytes from the devices come in on two valid/ready receive streams. They land in a single shared output buffer, and each byte is tagged with the channel it came from. The host learns the source from a status bit and is interrupted through one line per channel. The configuration byte can switch off either receive channel and enables each interrupt line separately. A prefix command sends only the single data write that follows it to the auxiliary channel.

Top module: `kbc_host_if`

## Requirements
- R1: After reset the configuration byte is 0x74, the status byte is 0x00, both interrupt outputs are low, and both receive streams hold ready low.
- R2: The status byte (host_addr=1 read) has bit 0 set while the output buffer holds a byte, bit 1 set while a host-written byte is still unaccepted, and bit 5 set while the held byte came from the auxiliary channel. Every other bit reads 0.
- R3: Command 0x60 (host_addr=1 write) makes the next data write (host_addr=0) load the configuration byte, with bits 3 and 7 forced to 0.
- R4: Command 0x20 puts the configuration byte into the output buffer, with status bit 5 clear and no interrupt. If the buffer is full, the command waits until the host has emptied it.
- R5: A data write goes to the main transmit stream. After command 0xD4, only the next data write goes to the auxiliary transmit stream.
- R6: The input-full flag stays set, and the byte stays held, until the command decoder or the selected transmit stream accepts it. A host write that arrives while the flag is set is dropped.
- R7: Configuration bit 4 disables the main receive channel and bit 5 disables the auxiliary one. A disabled channel keeps ready low and none of its bytes reach the output buffer.
- R8: When both channels offer a byte while the output buffer is empty, the main byte is taken. The auxiliary byte waits until the buffer is empty again.
- R9: A data-register read returns the held byte and clears status bit 0.
- R10: irq_main is high while the buffer holds a main-channel byte and configuration bit 0 is set. irq_aux is high while it holds an auxiliary byte and bit 1 is set.
- R11: A command other than 0x20, 0x60 or 0xD4 is consumed with no effect and cancels a pending 0x60 or 0xD4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | One-cycle host write strobe |
| host_rd | input | 1 | One-cycle host read strobe |
| host_addr | input | 1 | 0 selects data, 1 selects status/command |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| irq_main | output | 1 | Main-channel interrupt |
| irq_aux | output | 1 | Auxiliary-channel interrupt |
| main_tx_data | output | 8 | Byte toward the main device |
| main_tx_valid | output | 1 | Main transmit valid |
| main_tx_ready | input | 1 | Main transmit ready |
| aux_tx_data | output | 8 | Byte toward the auxiliary device |
| aux_tx_valid | output | 1 | Auxiliary transmit valid |
| aux_tx_ready | input | 1 | Auxiliary transmit ready |
| main_rx_data | input | 8 | Byte from the main device |
| main_rx_valid | input | 1 | Main receive valid |
| main_rx_ready | output | 1 | Main receive ready |
| aux_rx_data | input | 8 | Byte from the auxiliary device |
| aux_rx_valid | input | 1 | Auxiliary receive valid |
| aux_rx_ready | output | 1 | Auxiliary receive ready |

## Verification
Configuration writes use 0xFF, 0x88 and 0x47. The results tell correct masking of bits 3 and 7 apart from plain storage, and the configuration is read back through command 0x20, including once while the buffer is already full. Data writes are sent without a prefix, right after 0xD4, one write after that, and after 0xD4 followed by an unknown command. These cases separate one-shot routing from a sticky route and from a prefix that ignores cancellation. Received bytes arrive from each channel alone, from both at once, with interrupts enabled and disabled, and with a channel switched off. Together they distinguish the source tag, the priority order, interrupt gating and receive blocking.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {SRC_MAIN, SRC_AUX, SRC_CTRL} src_e;
  typedef enum logic [1:0] {PEND_NONE, PEND_CFG, PEND_AUX} pend_e;

  localparam logic [DATA_W-1:0] CMD_RD_CFG   = 8'h20;
  localparam logic [DATA_W-1:0] CMD_WR_CFG   = 8'h60;
  localparam logic [DATA_W-1:0] CMD_AUX_NEXT = 8'hD4;
  localparam logic [DATA_W-1:0] CFG_RESET    = 8'h74;
  localparam logic [DATA_W-1:0] CFG_KEEP     = 8'h77;

  localparam int CFG_IE_MAIN  = 0;
  localparam int CFG_IE_AUX   = 1;
  localparam int CFG_DIS_MAIN = 4;
  localparam int CFG_DIS_AUX  = 5;

  localparam int ST_OUT_FULL = 0;
  localparam int ST_IN_FULL  = 1;
  localparam int ST_FROM_AUX = 5;

  // Reserved configuration bits always read as zero.
  function automatic logic [DATA_W-1:0] cfg_clean(input logic [DATA_W-1:0] b);
    return b & CFG_KEEP;
  endfunction

  function automatic logic [DATA_W-1:0] status_word(input logic out_full,
                                                    input logic in_full,
                                                    input logic from_aux);
    logic [DATA_W-1:0] s;
    s = '0;
    s[ST_OUT_FULL] = out_full;
    s[ST_IN_FULL]  = in_full;
    s[ST_FROM_AUX] = from_aux;
    return s;
  endfunction
endpackage

// File: rtl/kbc_cmd_path.sv
module kbc_cmd_path
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              main_tx_ready,
  input  logic              aux_tx_ready,
  input  logic              reply_ack,
  output logic              main_tx_valid,
  output logic              aux_tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              reply_req,
  output logic [DATA_W-1:0] cfg,
  output logic              in_full
);
  logic [DATA_W-1:0] in_byte;
  logic              in_is_cmd;
  pend_e             pend;

  logic cmd_now, data_now, cfg_load, in_accept, host_take;

  assign cmd_now   = in_full && in_is_cmd;
  assign data_now  = in_full && !in_is_cmd;
  assign reply_req = cmd_now && (in_byte == CMD_RD_CFG);
  assign cfg_load  = data_now && (pend == PEND_CFG);

  assign main_tx_valid = data_now && (pend == PEND_NONE);
  assign aux_tx_valid  = data_now && (pend == PEND_AUX);
  assign tx_data       = in_byte;

  assign in_accept = (cmd_now && (!reply_req || reply_ack)) || cfg_load ||
                     (main_tx_valid && main_tx_ready) ||
                     (aux_tx_valid && aux_tx_ready);
  assign host_take = host_wr && !in_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_full   <= 1'b0;
      in_byte   <= '0;
      in_is_cmd <= 1'b0;
      pend      <= PEND_NONE;
      cfg       <= CFG_RESET;
    end else begin
      if (host_take) begin
        in_full   <= 1'b1;
        in_byte   <= host_wdata;
        in_is_cmd <= host_addr;
      end else if (in_accept) begin
        in_full <= 1'b0;
      end
      if (in_accept) begin
        if (cmd_now) begin
          case (in_byte)
            CMD_WR_CFG:   pend <= PEND_CFG;
            CMD_AUX_NEXT: pend <= PEND_AUX;
            CMD_RD_CFG:   pend <= pend;
            default:      pend <= PEND_NONE;
          endcase
        end else begin
          pend <= PEND_NONE;
        end
      end
      if (cfg_load) cfg <= cfg_clean(in_byte);
    end
  end

  // R6: an unaccepted byte stays put
  a_r6_hold_input: assert property (@(posedge clk) disable iff (!rst_n)
    (in_full && !in_accept) |=> (in_full && $stable(in_byte)));
  // R5: a data byte is offered to one channel at most
  a_r5_one_route: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_tx_valid && aux_tx_valid));
  // R3: reserved configuration bits stay clear after a load
  a_r3_cfg_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (cfg[3] == 1'b0 && cfg[7] == 1'b0));
endmodule

// File: rtl/kbc_out_buf.sv
module kbc_out_buf
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_data,
  input  logic              reply_req,
  input  logic [DATA_W-1:0] cfg,
  input  logic [DATA_W-1:0] main_rx_data,
  input  logic              main_rx_valid,
  input  logic [DATA_W-1:0] aux_rx_data,
  input  logic              aux_rx_valid,
  output logic              main_rx_ready,
  output logic              aux_rx_ready,
  output logic              reply_ack,
  output logic              ob_full,
  output logic [DATA_W-1:0] ob_data,
  output src_e              ob_src
);
  logic open, dis_main, dis_aux, main_take, aux_take, main_claims;

  assign open        = !ob_full;
  assign dis_main    = cfg[CFG_DIS_MAIN];
  assign dis_aux     = cfg[CFG_DIS_AUX];
  assign reply_ack   = open && reply_req;
  assign main_claims = main_rx_valid && !dis_main;

  assign main_rx_ready = open && !dis_main && !reply_req;
  assign aux_rx_ready  = open && !dis_aux && !reply_req && !main_claims;
  assign main_take     = main_rx_valid && main_rx_ready;
  assign aux_take      = aux_rx_valid && aux_rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ob_full <= 1'b0;
      ob_data <= '0;
      ob_src  <= SRC_CTRL;
    end else if (ob_full) begin
      if (rd_data) ob_full <= 1'b0;
    end else if (reply_ack) begin
      ob_full <= 1'b1;
      ob_data <= cfg;
      ob_src  <= SRC_CTRL;
    end else if (main_take) begin
      ob_full <= 1'b1;
      ob_data <= main_rx_data;
      ob_src  <= SRC_MAIN;
    end else if (aux_take) begin
      ob_full <= 1'b1;
      ob_data <= aux_rx_data;
      ob_src  <= SRC_AUX;
    end
  end

  // R9: reading the data register empties the buffer
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && ob_full) |=> !ob_full);
  // R8: never two receive handshakes in one cycle
  a_r8_single_take: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_take && aux_take));
  // R7: a newly loaded main byte was never taken from a disabled channel
  a_r7_no_disabled_load: assert property (@(posedge clk) disable iff (!rst_n)
    (main_take) |=> (ob_full && ob_src == SRC_MAIN && !$past(dis_main)));
endmodule

// File: rtl/kbc_irq.sv
module kbc_irq
  import kbc_pkg::*;
#(
  parameter int N_CH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ob_full,
  input  src_e            ob_src,
  input  logic            rd_data,
  input  logic [N_CH-1:0] ie,
  output logic [N_CH-1:0] irq
);
  genvar g;
  generate
    for (g = 0; g < N_CH; g++) begin : g_ch
      localparam src_e CH_SRC = (g == 0) ? SRC_MAIN : SRC_AUX;
      assign irq[g] = ob_full && (ob_src == CH_SRC) && ie[g];
    end
  endgenerate

  // R10: a data read drops every interrupt on the next cycle
  a_r10_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && ob_full) |=> (irq == '0));
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
  import kbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic       host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       irq_main,
  output logic       irq_aux,
  output logic [7:0] main_tx_data,
  output logic       main_tx_valid,
  input  logic       main_tx_ready,
  output logic [7:0] aux_tx_data,
  output logic       aux_tx_valid,
  input  logic       aux_tx_ready,
  input  logic [7:0] main_rx_data,
  input  logic       main_rx_valid,
  output logic       main_rx_ready,
  input  logic [7:0] aux_rx_data,
  input  logic       aux_rx_valid,
  output logic       aux_rx_ready
);
  logic [DATA_W-1:0] cfg, tx_data, ob_data;
  logic              in_full, reply_req, reply_ack, ob_full, rd_data;
  src_e              ob_src;
  logic [1:0]        irq_vec;

  assign rd_data = host_rd && !host_addr;

  kbc_cmd_path u_cmd (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .main_tx_ready(main_tx_ready),
    .aux_tx_ready(aux_tx_ready), .reply_ack(reply_ack),
    .main_tx_valid(main_tx_valid), .aux_tx_valid(aux_tx_valid),
    .tx_data(tx_data), .reply_req(reply_req), .cfg(cfg), .in_full(in_full)
  );

  kbc_out_buf u_obuf (
    .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .reply_req(reply_req),
    .cfg(cfg), .main_rx_data(main_rx_data), .main_rx_valid(main_rx_valid),
    .aux_rx_data(aux_rx_data), .aux_rx_valid(aux_rx_valid),
    .main_rx_ready(main_rx_ready), .aux_rx_ready(aux_rx_ready),
    .reply_ack(reply_ack), .ob_full(ob_full), .ob_data(ob_data),
    .ob_src(ob_src)
  );

  kbc_irq #(.N_CH(2)) u_irq (
    .clk(clk), .rst_n(rst_n), .ob_full(ob_full), .ob_src(ob_src),
    .rd_data(rd_data), .ie({cfg[CFG_IE_AUX], cfg[CFG_IE_MAIN]}),
    .irq(irq_vec)
  );

  assign irq_main     = irq_vec[0];
  assign irq_aux      = irq_vec[1];
  assign main_tx_data = tx_data;
  assign aux_tx_data  = tx_data;
  assign host_rdata   = host_addr
                        ? status_word(ob_full, in_full, ob_full && ob_src == SRC_AUX)
                        : ob_data;

  // R4: the controller's own reply never raises an interrupt
  a_r4_reply_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reply_ack |=> (!irq_main && !irq_aux));
endmodule

// File: tb/kbc_host_if_tb_top.sv
module kbc_host_if_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic irq_main, irq_aux;
  logic [7:0] main_tx_data, aux_tx_data;
  logic main_tx_valid, aux_tx_valid;
  logic main_tx_ready = 1, aux_tx_ready = 1;
  logic [7:0] main_rx_data = 0, aux_rx_data = 0;
  logic main_rx_valid = 0, aux_rx_valid = 0;
  logic main_rx_ready, aux_rx_ready;

  int n_chk = 0, n_fail = 0;
  int main_cnt = 0, aux_cnt = 0;
  logic [7:0] main_last = 0, aux_last = 0;

  always #5 clk = ~clk;

  kbc_host_if dut_i (.*);

  always @(posedge clk) if (rst_n) begin
    if (main_tx_valid && main_tx_ready) begin main_cnt++; main_last = main_tx_data; end
    if (aux_tx_valid && aux_tx_ready) begin aux_cnt++; aux_last = aux_tx_data; end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Every access takes one cycle; called and returning at a falling edge.
  task automatic op(input int kind, input logic a, input logic [7:0] d, output logic [7:0] r);
    host_addr = a;
    host_wdata = d;
    host_wr = (kind == 0);
    host_rd = (kind == 1);
    #1 r = host_rdata;
    @(negedge clk);
    host_wr = 0;
    host_rd = 0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    logic [7:0] x;
    op(0, a, d, x);
    op(2, 0, 0, x);
  endtask

  task automatic rd_chk(input string tag, input logic a, input logic [7:0] exp);
    logic [7:0] x;
    op(1, a, 0, x);
    chk(tag, x, exp);
  endtask

  task automatic rx_main(input logic [7:0] d);
    main_rx_data = d;
    main_rx_valid = 1;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (main_rx_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    main_rx_valid = 0;
  endtask

  task automatic rx_aux(input logic [7:0] d);
    aux_rx_data = d;
    aux_rx_valid = 1;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (aux_rx_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    aux_rx_valid = 0;
  endtask

  // {kind, addr, data, expected, requirement}; kind 0 write, 1 read+check, 2 idle
  localparam int NV = 31;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 1'b1, 8'h20, 8'h00, 4'd1},  // R1 read back reset configuration
    {2'd2, 1'b0, 8'h00, 8'h00, 4'd1},
    {2'd1, 1'b1, 8'h00, 8'h01, 4'd2},  // R2 output full
    {2'd1, 1'b0, 8'h00, 8'h74, 4'd1},  // R1 reset value 0x74
    {2'd1, 1'b1, 8'h00, 8'h00, 4'd9},  // R9 cleared by read
    {2'd0, 1'b1, 8'h60, 8'h00, 4'd3},
    {2'd1, 1'b1, 8'h00, 8'h02, 4'd2},  // R2 input full
    {2'd0, 1'b0, 8'hFF, 8'h00, 4'd3},
    {2'd2, 1'b0, 8'h00, 8'h00, 4'd3},
    {2'd0, 1'b1, 8'h20, 8'h00, 4'd4},
    {2'd2, 1'b0, 8'h00, 8'h00, 4'd4},
    {2'd1, 1'b0, 8'h00, 8'h77, 4'd3},  // R3 bits 3 and 7 masked
    {2'd0, 1'b1, 8'h60, 8'h00, 4'd3},
    {2'd2, 1'b0, 8'h00, 8'h00, 4'd3},
    {2'd0, 1'b0, 8'h88, 8'h00, 4'd3},
    {2'd2, 1'b0, 8'h00, 8'h00, 4'd3},
    {2'd0, 1'b1, 8'h20, 8'h00, 4'd3},
    {2'd2, 1'b0, 8'h00, 8'h00, 4'd3},
    {2'd1, 1'b0, 8'h00, 8'h00, 4'd3},  // R3 0x88 stores as 0x00
    {2'd0, 1'b1, 8'h60, 8'h00, 4'd3},
    {2'd2, 1'b0, 8'h00, 8'h00, 4'd3},
    {2'd0, 1'b0, 8'h47, 8'h00, 4'd3},
    {2'd2, 1'b0, 8'h00, 8'h00, 4'd3},
    {2'd0, 1'b1, 8'h20, 8'h00, 4'd4},
    {2'd2, 1'b0, 8'h00, 8'h00, 4'd4},
    {2'd0, 1'b1, 8'h20, 8'h00, 4'd4},  // R4 second reply must wait
    {2'd1, 1'b1, 8'h00, 8'h03, 4'd4},
    {2'd1, 1'b0, 8'h00, 8'h47, 4'd4},
    {2'd2, 1'b0, 8'h00, 8'h00, 4'd4},
    {2'd1, 1'b1, 8'h00, 8'h01, 4'd4},  // R4 reply tagged non-aux
    {2'd1, 1'b0, 8'h00, 8'h47, 4'd4}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] x;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 status", host_rdata, 8'h00);  // host_addr=0 shows data; read status next
    host_addr = 1; #1;
    chk("R1 status", host_rdata, 8'h00);
    chk("R1 irqs", {6'd0, irq_aux, irq_main}, 8'h00);
    chk("R1 readies", {6'd0, aux_rx_ready, main_rx_ready}, 8'h00);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      op(int'(VEC[i][22:21]), VEC[i][20], VEC[i][19:12], x);
      if (VEC[i][22:21] == 2'd1)
        chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), x, VEC[i][11:4]);
    end

    // R5 routing, one-shot prefix
    wr(0, 8'h6B);
    chk("R5 main count", 8'(main_cnt), 8'd1);
    chk("R5 main byte", main_last, 8'h6B);
    wr(1, 8'hD4);
    wr(0, 8'h5A);
    chk("R5 aux count", 8'(aux_cnt), 8'd1);
    chk("R5 aux byte", aux_last, 8'h5A);
    wr(0, 8'h3C);
    chk("R5 back to main", main_last, 8'h3C);
    chk("R5 aux unchanged", 8'(aux_cnt), 8'd1);

    // R11 unknown command cancels the prefix
    wr(1, 8'hD4);
    wr(1, 8'hAA);
    wr(0, 8'h33);
    chk("R11 main byte", main_last, 8'h33);
    chk("R11 aux unchanged", 8'(aux_cnt), 8'd1);
    rd_chk("R11 no output", 1, 8'h00);

    // R6 hold until accepted, drop writes while full
    main_tx_ready = 0;
    op(0, 0, 8'h11, x);
    rd_chk("R6 input full", 1, 8'h02);
    op(0, 0, 8'h22, x);
    op(2, 0, 0, x);
    rd_chk("R6 still full", 1, 8'h02);
    main_tx_ready = 1;
    op(2, 0, 0, x);
    op(2, 0, 0, x);
    chk("R6 count", 8'(main_cnt), 8'd4);
    chk("R6 held byte", main_last, 8'h11);
    rd_chk("R6 cleared", 1, 8'h00);

    // R9/R10 main receive with interrupts on
    rx_main(8'h1C);
    rd_chk("R2 main source", 1, 8'h01);
    chk("R10 irq main", {6'd0, irq_aux, irq_main}, 8'h01);
    rd_chk("R9 data", 0, 8'h1C);
    #1 chk("R10 irq cleared", {6'd0, irq_aux, irq_main}, 8'h00);
    rd_chk("R9 status", 1, 8'h00);
    rx_aux(8'hF0);
    rd_chk("R2 aux source", 1, 8'h21);
    chk("R10 irq aux", {6'd0, irq_aux, irq_main}, 8'h02);
    rd_chk("R9 aux data", 0, 8'hF0);

    // R8 main wins
    main_rx_data = 8'hA1; aux_rx_data = 8'hB2;
    main_rx_valid = 1; aux_rx_valid = 1;
    #1 chk("R8 readies", {6'd0, aux_rx_ready, main_rx_ready}, 8'h01);
    @(negedge clk);
    main_rx_valid = 0;
    rd_chk("R8 main first status", 1, 8'h01);
    rd_chk("R8 main first data", 0, 8'hA1);
    #1 chk("R8 aux ready", {7'd0, aux_rx_ready}, 8'h01);
    @(negedge clk);
    aux_rx_valid = 0;
    rd_chk("R8 aux later status", 1, 8'h21);
    rd_chk("R8 aux later data", 0, 8'hB2);

    // R10 interrupts disabled
    wr(1, 8'h60); wr(0, 8'h44);
    rx_main(8'h2E);
    rd_chk("R10 gated status", 1, 8'h01);
    chk("R10 gated irq", {6'd0, irq_aux, irq_main}, 8'h00);
    rd_chk("R10 gated data", 0, 8'h2E);

    // R7 disabled channels
    wr(1, 8'h60); wr(0, 8'h77);
    main_rx_data = 8'h99; main_rx_valid = 1;
    aux_rx_data = 8'h98; aux_rx_valid = 1;
    repeat (4) begin
      #1 chk("R7 readies low", {6'd0, aux_rx_ready, main_rx_ready}, 8'h00);
      @(negedge clk);
    end
    main_rx_valid = 0; aux_rx_valid = 0;
    rd_chk("R7 nothing loaded", 1, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule